// File: doc/BRIEF.md
# Chainable SPI Register Port

This block is a serial slave that lets a host read and write a small bank of 16-bit registers over a four-wire serial link. Each transfer is one 24-bit word framed by an active-low chip select. The word holds a read/write flag, a 7-bit register address and a 16-bit data field.

The command in a word acts when chip select returns high. The answer to a read is not returned at once: it goes out on the serial output during the next frame, whatever that frame carries. When the previous frame was not a read, the output repeats that frame's word unchanged. The output also streams every input bit out again 24 clocks later. Because of this, several of these ports can sit in series on one chip select, with the host shifting 24 bits per device.

A mode input turns the port on and off, so a board can hand the pins to another serial protocol. All pin inputs are brought into the core clock domain by a synchronizer. The serial clock must therefore run well below the core clock.

Top module: `spireg_top`

## Requirements
- R1: Input bits are taken on each rising serial-clock edge while chip select is low, most significant bit first. A frame is 24 bits long.
- R2: In a committed word, bit 23 set to 1 means read and 0 means write. Bits 22:16 are the register address and bits 15:0 are the write data.
- R3: A committed write updates the addressed register when chip select rises. A write to an address at or above the register count changes nothing, and a read of such an address returns 0.
- R4: After a committed read, the next frame's first 24 output bits are the read word's bits 23:16 followed by the 16-bit register content. This holds whatever the next frame carries.
- R5: After a committed write, the next frame's first 24 output bits repeat that write word unchanged.
- R6: Once the first 24 bits of a frame have gone out, each later output bit is the input bit taken 24 serial-clock edges earlier.
- R7: A frame whose bit count is zero or not a multiple of 24 is discarded. No register changes, and the next frame's reply is the same as it would have been without the discarded frame.
- R8: The output-enable is low whenever chip select is high or the port is disabled, and high during a frame on an enabled port.
- R9: While the mode input is low, all serial traffic is ignored. Registers and the pending reply stay unchanged, and the data output stays at 0.
- R10: After reset every register is 0, the pending reply is 0 and the output-enable is low.
- R11: When a frame carries 48 bits, the port commits the last 24 bits received. During the second 24 bits it outputs the first 24 bits, so the earlier word reaches the next device in the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sel | input | 1 | Port enable; high selects this serial port |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output (0 when not enabled) |
| sdo_oe | output | 1 | Output-enable for the external tri-state driver of sdo |

## Verification
Two functions share one register in the same frame: loading the pending reply at the start of a frame, and shifting input bits through the same word on every serial edge. Because of this sharing, the reply, the echo and the pass-through all travel in the same 24 bits. The bench provokes this overlap with frames whose command differs from the one before, with 48-bit chained frames and with truncated frames. It predicts every output bit from a model of the registers and the pending reply. A read followed directly by a write to the same address shows whether the reply was captured at the read's commit or wrongly refetched later.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
  localparam int FRAME_W = 24;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 16;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;

  // Word to return in the next frame once a frame has committed.
  function automatic logic [FRAME_W-1:0] make_reply(frame_t f, logic [DATA_W-1:0] rdata);
    if (f.rd) return {f.rd, f.addr, rdata};
    return f;
  endfunction

  // A frame counts only if it shifted at least one whole word and ended on a word boundary.
  function automatic logic frame_whole(logic seen, logic [$clog2(FRAME_W)-1:0] cnt);
    return seen && (cnt == '0);
  endfunction
endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
  parameter int             W      = 4,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   INIT   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_sync,
  output logic [W-1:0] d_rise,
  output logic [W-1:0] d_fall
);
  logic [W-1:0] pipe [STAGES+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k <= STAGES; k++) pipe[k] <= INIT;
    end else begin
      pipe[0] <= d_in;
      for (int k = 1; k <= STAGES; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign d_sync = pipe[STAGES-1];
  assign d_rise = pipe[STAGES-1] & ~pipe[STAGES];
  assign d_fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/spireg_shifter.sv
module spireg_shifter #(
  parameter int FW = 24,
  localparam int CW = $clog2(FW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] load_val,
  input  logic          shift,
  input  logic          bit_in,
  output logic [FW-1:0] word,
  output logic [CW-1:0] bit_cnt,
  output logic          seen
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= '0;
      bit_cnt <= '0;
      seen    <= 1'b0;
    end else if (load) begin
      word    <= load_val;
      bit_cnt <= '0;
      seen    <= 1'b0;
    end else if (shift) begin
      word    <= {word[FW-2:0], bit_in};
      bit_cnt <= (bit_cnt == CW'(FW-1)) ? '0 : bit_cnt + 1'b1;
      seen    <= 1'b1;
    end
  end
endmodule

// File: rtl/spireg_bank.sv
module spireg_bank #(
  parameter int NREG = 8,
  parameter int AW   = 7,
  parameter int DW   = 16,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 regs[g] <= '0;
      else if (wr_en && (wr_addr == AW'(g)))      regs[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr < AW'(NREG)) rd_data = regs[rd_addr[IW-1:0]];
  end
endmodule

// File: rtl/spireg_top.sv
module spireg_top
  import spireg_pkg::*;
#(
  parameter int NREG        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sel,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);
  localparam int CW = $clog2(FRAME_W);

  logic [3:0] pin_s, pin_r, pin_f;
  logic en, cs_s, sdi_s;
  logic frame_start, frame_end, frame_ok, shift_evt;
  logic [FRAME_W-1:0] word, reply_q;
  logic [CW-1:0] bit_cnt;
  logic seen;
  frame_t cmd;
  logic [DATA_W-1:0] rd_data;

  spireg_sync #(.W(4), .STAGES(SYNC_STAGES), .INIT(4'b0100)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_in({spi_sel, cs_n, sclk, sdi}),
    .d_sync(pin_s), .d_rise(pin_r), .d_fall(pin_f)
  );

  assign en          = pin_s[3];
  assign cs_s        = pin_s[2];
  assign sdi_s       = pin_s[0];
  assign frame_start = en & pin_f[2];
  assign frame_end   = en & pin_r[2];
  assign shift_evt   = en & ~cs_s & pin_r[1];

  spireg_shifter #(.FW(FRAME_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .load(frame_start), .load_val(reply_q),
    .shift(shift_evt), .bit_in(sdi_s), .word(word), .bit_cnt(bit_cnt), .seen(seen)
  );

  assign cmd      = frame_t'(word);
  assign frame_ok = frame_end & frame_whole(seen, bit_cnt);

  spireg_bank #(.NREG(NREG), .AW(ADDR_W), .DW(DATA_W)) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_en(frame_ok & ~cmd.rd), .wr_addr(cmd.addr),
    .wr_data(cmd.data), .rd_addr(cmd.addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        reply_q <= '0;
    else if (frame_ok) reply_q <= make_reply(cmd, rd_data);
  end

  assign sdo_oe = en & ~cs_s;
  assign sdo    = sdo_oe & word[FRAME_W-1];
endmodule

// File: rtl/spireg_checker.sv
module spireg_checker #(
  parameter int FW = 24,
  localparam int CW = $clog2(FW)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          sdo_oe,
  input logic          shift_evt,
  input logic          frame_start,
  input logic          frame_end,
  input logic          frame_ok,
  input logic [CW-1:0] bit_cnt,
  input logic [FW-1:0] word,
  input logic          sdi_s,
  input logic [FW-1:0] reply_q
);
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) bit_cnt < CW'(FW)); // R1
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_evt && !frame_start) |=> (word == {$past(word[FW-2:0]), $past(sdi_s)})); // R6
  AST_LOAD_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (word == $past(reply_q))); // R4
  AST_DISCARD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !frame_ok) |=> $stable(reply_q)); // R7
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(word) && $stable(reply_q))); // R9
  AST_OE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> !sdo_oe); // R8
endmodule

bind spireg_top spireg_checker #(.FW(spireg_pkg::FRAME_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .sdo_oe(sdo_oe), .shift_evt(shift_evt),
  .frame_start(frame_start), .frame_end(frame_end), .frame_ok(frame_ok),
  .bit_cnt(bit_cnt), .word(word), .sdi_s(sdi_s), .reply_q(reply_q)
);

// File: tb/spireg_top_tb_top.sv
module spireg_top_tb_top;
  localparam int NREG = 8;
  logic clk = 0, rst_n = 0, spi_sel = 1, cs_n = 1, sclk = 0, sdi = 0;
  logic sdo, sdo_oe;
  int n_chk = 0, n_bad = 0;
  logic [15:0] m_regs [NREG];
  logic [23:0] m_reply;

  always #2.5 clk = ~clk;

  spireg_top #(.NREG(NREG)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sel(spi_sel), .cs_n(cs_n),
    .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  function automatic logic [15:0] m_read(logic [6:0] a);
    return (a < 7'(NREG)) ? m_regs[a[2:0]] : 16'h0;
  endfunction

  task automatic check(input logic ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [47:0] bits, input int n, input string req);
    logic [47:0] got, exp;
    logic oe_hi, oe_lo;
    got = '0; exp = '0; oe_hi = 1'b1; oe_lo = 1'b1;
    @(negedge clk); cs_n = 0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = bits[n-1-i];
      repeat (4) @(negedge clk);
      got[n-1-i] = sdo;
      if (sdo_oe) oe_lo = 1'b0; else oe_hi = 1'b0;
      exp[n-1-i] = (i < 24) ? m_reply[23-i] : bits[n-1-(i-24)];
      sclk = 1;
      repeat (4) @(negedge clk);
      sclk = 0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1;
    repeat (8) @(negedge clk);
    if (spi_sel) begin
      check(got == exp, req, got, exp);
      check(oe_hi && !sdo_oe, "R8", {46'h0, oe_hi, sdo_oe}, 48'h2);
      if (n > 0 && (n % 24) == 0) begin
        if (bits[23]) m_reply = {bits[23:16], m_read(bits[22:16])};
        else begin
          if (bits[22:16] < 7'(NREG)) m_regs[bits[18:16]] = bits[15:0];
          m_reply = bits[23:0];
        end
      end
    end else begin
      check(oe_lo && got == 48'h0, "R9", got, 48'h0);
    end
  endtask

  function automatic logic [47:0] wr(logic [6:0] a, logic [15:0] d);
    return {24'h0, 1'b0, a, d};
  endfunction
  function automatic logic [47:0] rd(logic [6:0] a);
    return {24'h0, 1'b1, a, 16'h0};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    for (int k = 0; k < NREG; k++) m_regs[k] = 16'h0;
    m_reply = 24'h0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(!sdo_oe, "R10", {47'h0, sdo_oe}, 48'h0);
    run_frame(wr(7'd3, 16'hA5C3), 24, "R1/R10");
    run_frame(rd(7'd3), 24, "R5");
    run_frame(wr(7'd3, 16'h1111), 24, "R2/R4");
    run_frame(rd(7'd3), 24, "R3");
    run_frame(wr(7'd3, 16'hBEEF) >> 4, 20, "R7");
    run_frame(rd(7'd3), 24, "R7");
    run_frame(wr(7'd0, 16'h0F0F), 24, "R7");
    run_frame(wr(7'h40, 16'h7777), 24, "R3");
    run_frame(rd(7'h40), 24, "R3");
    run_frame(wr(7'd1, 16'h2222), 24, "R3");
    run_frame({1'b1, 7'd2, 16'h0, 1'b0, 7'd1, 16'hC0DE}, 48, "R11/R6");
    run_frame(rd(7'd1), 24, "R11");
    run_frame(48'h0, 0, "R7");
    run_frame(rd(7'd1), 24, "R7");
    @(negedge clk); spi_sel = 0;
    repeat (6) @(negedge clk);
    run_frame(wr(7'd1, 16'h9999), 24, "R9");
    @(negedge clk); spi_sel = 1;
    repeat (6) @(negedge clk);
    run_frame(rd(7'd1), 24, "R9");
    run_frame(wr(7'd5, 16'h0), 24, "R4");
    for (int t = 0; t < 60; t++) begin
      logic [47:0] b;
      int n, sel;
      b = {$urandom(seed), $urandom()};
      seed = 0;
      b[22:19] = 4'h0;
      b[18:16] = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 7) == 0) b[22:16] = 7'h41;
      sel = $urandom_range(0, 9);
      n = (sel < 7) ? 24 : (sel < 9) ? 48 : 23;
      run_frame(b, n, (n == 48) ? "R6" : (n == 23) ? "R7" : "R4");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule